// File: doc/BRIEF.md
# Repeat-Cycle Gated Interval Timer

This block measures out a repeating interval on a shared time base. A rising edge on the start input sets it running. From then on it advances one step on every enabled tick. After a programmed number of ticks it wraps and begins the next interval by itself, with no further start needed. The elapsed value can be shown counting up from zero or counting down from the programmed length. A gate input pauses the count without losing its place.

The timer output has two behaviours, chosen by the pulse-width value. A width of zero makes the output a square wave that inverts at the close of every interval. A non-zero width makes the output a pulse of that many ticks at the opening of every interval. A clear input is accepted only after it has been held for a programmable number of clock cycles. An accepted clear stops the timer until a fresh start edge arrives. A retain input stands in for loss of power. While it is high the output is dark and the timer is frozen. When it drops, the output comes back at its stored level. The stored count then waits for a new start edge before it moves again.

Top module: `cyc_timer`

## Requirements
- R1: When idle, a rising edge on `start_in` sets the timer running. A falling edge on `start_in` has no effect, and so does a rising edge that arrives while the timer is already running.
- R2: In up mode (`dir_down`=0) `elapsed` begins at 0 and rises by one on each qualifying tick. It returns to 0 on the tick that completes `period_val` ticks. A `period_val` of 0 is treated as 1.
- R3: In down mode (`dir_down`=1) `elapsed` equals the effective period minus the up-count. It therefore runs from the period value down to 1.
- R4: With `width_val`=0 the output is low after a clear, and it inverts at the close of every interval.
- R5: With a non-zero `width_val` the output rises in the cycle after a start edge or an interval wrap. It stays high for `width_val` qualifying ticks.
- R6: When `width_val` is greater than or equal to the effective period, the output stays high through every interval while the timer runs.
- R7: While `gate_in` is high, both the interval count and the pulse-width count hold. Both resume when `gate_in` falls.
- R8: A clear is accepted on the clock edge where `clr_in` has been high for `clr_min` consecutive cycles, with 0 treated as 1. An accepted clear drives the output low, sets the up-count to 0 and stops the timer until a new start rising edge. A shorter assertion has no effect.
- R9: An accepted clear wins over a start edge and over gate in the same cycle, and that start edge is lost.
- R10: While `hold_in` is high the output reads 0, the count does not move, and the start and clear inputs are ignored. After `hold_in` falls, the output returns to its stored level. The count keeps its stored value and resumes from it only after a new start rising edge.
- R11: A cycle with `tick_en` low advances neither the interval count nor the pulse-width count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick qualifier |
| start_in | input | 1 | Start request, rising edge active |
| clr_in | input | 1 | Clear request, level held for `clr_min` cycles |
| gate_in | input | 1 | Pause while high |
| hold_in | input | 1 | Retained-state hold (power absent) |
| dir_down | input | 1 | 1: elapsed shown counting down |
| period_val | input | W | Interval length in ticks |
| width_val | input | W | Pulse width in ticks, 0 selects toggle output |
| clr_min | input | CW | Minimum clear hold in clock cycles |
| tmr_out | output | 1 | Timer output |
| elapsed | output | W | Current interval position |

## Verification
A corrupted up-count shows on `elapsed` in the very next sampled cycle. In either direction the bench predicts that value from the tick number modulo the period. A wrong output level or a lost toggle phase shows on `tmr_out` within one interval, because the bench recomputes the expected level from the tick index and the width. A wrong idle or retained state stays hidden until the next tick. It then shows as `elapsed` moving when it should be frozen, or standing still when it should move.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // qualified requests from the input conditioner
    typedef struct packed {
        logic start;   // accepted rising edge of start
        logic clr;     // clear met its minimum width this cycle
    } req_t;

    // per-cycle events from the interval counter
    typedef struct packed {
        logic adv;      // counting tick this cycle
        logic begin_p;  // a new interval opens at this edge
        logic end_p;    // the current interval closes at this edge
    } prd_ev_t;

    // zero-length settings are read as one
    function automatic logic [31:0] eff_len(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/cyc_edge_cond.sv
module cyc_edge_cond
    import cyc_timer_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_in,
    input  logic          start_in,
    input  logic          clr_in,
    input  logic [CW-1:0] clr_min,
    output req_t          req
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic          start_q;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] thr_m1;

    always_comb begin
        thr_m1    = (clr_min == '0) ? '0 : clr_min - 1'b1;
        req.start = start_in & ~start_q & ~hold_in;
        req.clr   = clr_in & ~hold_in & (hi_cnt == thr_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            hi_cnt  <= '0;
        end else begin
            start_q <= start_in;
            if (hold_in || !clr_in)
                hi_cnt <= '0;
            else if (hi_cnt != SAT)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cyc_period.sv
module cyc_period
    import cyc_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_in,
    input  logic         tick_en,
    input  logic         gate_in,
    input  req_t         req,
    input  logic [W-1:0] period_val,
    output prd_ev_t      ev,
    output logic [W-1:0] tcnt,
    output run_st_e      st
);
    logic [W-1:0] last_idx;
    logic         wrap;

    always_comb begin
        last_idx   = (period_val == '0) ? '0 : period_val - 1'b1;
        ev.adv     = (st == ST_RUN) & tick_en & ~gate_in & ~hold_in & ~req.clr;
        wrap       = ev.adv & (tcnt >= last_idx);
        ev.end_p   = wrap;
        ev.begin_p = ~req.clr & (wrap | ((st == ST_IDLE) & req.start & (tcnt == '0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            tcnt <= '0;
        end else if (hold_in) begin
            st   <= ST_IDLE;
        end else if (req.clr) begin
            st   <= ST_IDLE;
            tcnt <= '0;
        end else begin
            if (st == ST_IDLE && req.start)
                st <= ST_RUN;
            if (ev.adv)
                tcnt <= wrap ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cyc_pulse.sv
module cyc_pulse
    import cyc_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_in,
    input  req_t         req,
    input  prd_ev_t      ev,
    input  logic [W-1:0] width_val,
    output logic         lvl
);
    logic [W-1:0] pcnt;
    logic         toggle_mode;
    logic [W-1:0] width_m1;

    always_comb begin
        toggle_mode = (width_val == '0);
        width_m1    = width_val - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= 1'b0;
            pcnt <= '0;
        end else if (hold_in) begin
            lvl  <= lvl;
        end else if (req.clr) begin
            lvl  <= 1'b0;
            pcnt <= '0;
        end else if (toggle_mode) begin
            if (ev.end_p)
                lvl <= ~lvl;
        end else if (ev.begin_p) begin
            lvl  <= 1'b1;
            pcnt <= '0;
        end else if (lvl && ev.adv) begin
            if (pcnt >= width_m1)
                lvl <= 1'b0;
            else
                pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          start_in,
    input  logic          clr_in,
    input  logic          gate_in,
    input  logic          hold_in,
    input  logic          dir_down,
    input  logic [W-1:0]  period_val,
    input  logic [W-1:0]  width_val,
    input  logic [CW-1:0] clr_min,
    output logic          tmr_out,
    output logic [W-1:0]  elapsed
);
    req_t         req;
    prd_ev_t      pev;
    logic [W-1:0] tcnt;
    run_st_e      st;
    logic         lvl;
    logic [W-1:0] per_eff;

    cyc_edge_cond #(.CW(CW)) u_cond (
        .clk(clk), .rst(rst), .hold_in(hold_in),
        .start_in(start_in), .clr_in(clr_in), .clr_min(clr_min),
        .req(req)
    );

    cyc_period #(.W(W)) u_per (
        .clk(clk), .rst(rst), .hold_in(hold_in), .tick_en(tick_en),
        .gate_in(gate_in), .req(req), .period_val(period_val),
        .ev(pev), .tcnt(tcnt), .st(st)
    );

    cyc_pulse #(.W(W)) u_pls (
        .clk(clk), .rst(rst), .hold_in(hold_in), .req(req),
        .ev(pev), .width_val(width_val), .lvl(lvl)
    );

    always_comb begin
        per_eff = W'(eff_len(32'(period_val)));
        tmr_out = lvl & ~hold_in;
        elapsed = dir_down ? (per_eff - tcnt) : tcnt;
    end
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         gate_in,
    input logic [W-1:0] width_val,
    input logic         clr_acc,
    input logic         start_acc,
    input logic         idle,
    input logic         begin_p,
    input logic         end_p,
    input logic [W-1:0] tcnt,
    input logic         lvl
);
    assert_clr_stops_R8: assert property (@(posedge clk) disable iff (rst)
        clr_acc |=> (tcnt == '0) && idle && !lvl);

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_acc && start_acc) |=> idle);

    assert_gate_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_in && !clr_acc) |=> $stable(tcnt));

    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (idle && !clr_acc) |=> $stable(tcnt));

    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (end_p && width_val == '0) |=> (lvl != $past(lvl)));

    assert_pulse_open_R5: assert property (@(posedge clk) disable iff (rst)
        (begin_p && width_val != '0) |=> lvl);
endmodule

bind cyc_timer cyc_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .gate_in(gate_in), .width_val(width_val),
    .clr_acc(req.clr), .start_acc(req.start),
    .idle(st == cyc_timer_pkg::ST_IDLE),
    .begin_p(pev.begin_p), .end_p(pev.end_p),
    .tcnt(tcnt), .lvl(lvl)
);

// File: tb/sim_cyc_timer.sv
`timescale 1ns/1ps
module sim_cyc_timer;
    localparam int W  = 8;
    localparam int CW = 4;
    localparam int WATCH = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b1;
    logic          start_in = 1'b0;
    logic          clr_in = 1'b0;
    logic          gate_in = 1'b0;
    logic          hold_in = 1'b0;
    logic          dir_down = 1'b0;
    logic [W-1:0]  period_val = 8'd4;
    logic [W-1:0]  width_val = '0;
    logic [CW-1:0] clr_min = 4'd1;
    logic          tmr_out;
    logic [W-1:0]  elapsed;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cyc_timer #(.W(W), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start_in(start_in),
        .clr_in(clr_in), .gate_in(gate_in), .hold_in(hold_in),
        .dir_down(dir_down), .period_val(period_val), .width_val(width_val),
        .clr_min(clr_min), .tmr_out(tmr_out), .elapsed(elapsed)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        clr_in = 1'b1;
        step();
        clr_in = 1'b0;
    endtask

    task automatic do_start();
        start_in = 1'b1;
        step();
        start_in = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCH && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCH);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // reset state
        chk("R8 reset out", int'(tmr_out), 0);
        chk("R2 reset elapsed", int'(elapsed), 0);

        // sweep: period, width, direction
        for (int d = 0; d < 2; d++) begin
            for (int p = 1; p <= 6; p++) begin
                for (int w = 0; w <= 7; w++) begin
                    dir_down   = 1'(d);
                    period_val = W'(p);
                    width_val  = W'(w);
                    do_clear();
                    chk("R8 cleared out", int'(tmr_out), 0);
                    chk(d ? "R3 cleared" : "R2 cleared", int'(elapsed), d ? p : 0);
                    do_start();
                    for (int n = 0; n < 3 * p; n++) begin
                        int ph, eo, ee;
                        if (n > 0) step();
                        ph = n % p;
                        ee = d ? (p - ph) : ph;
                        if (w == 0)      eo = (n / p) % 2;
                        else if (w >= p) eo = 1;
                        else             eo = (ph < w) ? 1 : 0;
                        chk(d ? "R3 elapsed" : "R2 elapsed", int'(elapsed), ee);
                        chk(w == 0 ? "R4 toggle" : (w >= p ? "R6 long pulse" : "R5 pulse"),
                            int'(tmr_out), eo);
                    end
                end
            end
        end
        dir_down = 1'b0;

        // R2: period value 0 treated as 1
        period_val = '0; width_val = '0;
        do_clear(); do_start();
        chk("R2 zero period", int'(elapsed), 0);
        step();
        chk("R2 zero period out", int'(tmr_out), 1);
        step();
        chk("R2 zero period out2", int'(tmr_out), 0);

        // R1: falling edge and repeated start while running
        period_val = 8'd5; width_val = 8'd2;
        do_clear();
        start_in = 1'b1; step();
        step(); step();
        start_in = 1'b0; step();
        chk("R1 fall no effect", int'(elapsed), 3);
        start_in = 1'b1; step();
        chk("R1 restart ignored", int'(elapsed), 4);
        start_in = 1'b0; step();
        chk("R1 wrap", int'(elapsed), 0);
        step();
        chk("R1 next", int'(elapsed), 1);

        // R11: tick qualifier
        tick_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R11 no tick", int'(elapsed), 1);
        end
        tick_en = 1'b1; step();
        chk("R11 tick resumes", int'(elapsed), 2);

        // R7: gate freezes count and pulse width
        period_val = 8'd6; width_val = 8'd4;
        do_clear(); do_start(); step();
        chk("R7 pre gate", int'(elapsed), 1);
        gate_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 gated elapsed", int'(elapsed), 1);
            chk("R7 gated out", int'(tmr_out), 1);
        end
        gate_in = 1'b0;
        step(); chk("R7 resume", int'(elapsed), 2);
        step(); chk("R7 pulse held", int'(tmr_out), 1);
        step(); chk("R7 pulse len e", int'(elapsed), 4);
        chk("R7 pulse len o", int'(tmr_out), 0);

        // R8: minimum clear width
        period_val = 8'd8; width_val = '0;
        do_clear(); do_start();
        clr_min = 4'd3;
        clr_in = 1'b1; step(); step();
        clr_in = 1'b0; step();
        chk("R8 short clear ignored", int'(elapsed), 3);
        clr_in = 1'b1; step(); step(); step();
        chk("R8 clear accepted", int'(elapsed), 0);
        chk("R8 clear out", int'(tmr_out), 0);
        step(); step();
        chk("R8 stays idle", int'(elapsed), 0);
        clr_in = 1'b0; clr_min = 4'd1;
        do_start(); step();
        chk("R8 restart", int'(elapsed), 1);

        // R9: clear beats start and gate in the same cycle
        width_val = 8'd3;
        do_clear(); do_start(); step();
        chk("R9 running out", int'(tmr_out), 1);
        clr_in = 1'b1; gate_in = 1'b1; start_in = 1'b1;
        step();
        clr_in = 1'b0; gate_in = 1'b0;
        chk("R9 cleared elapsed", int'(elapsed), 0);
        chk("R9 cleared out", int'(tmr_out), 0);
        step(); step();
        chk("R9 start lost", int'(elapsed), 0);
        start_in = 1'b0;

        // R10: retained-state hold and restore
        period_val = 8'd3; width_val = '0;
        do_clear(); do_start();
        repeat (4) step();
        chk("R10 pre hold e", int'(elapsed), 1);
        chk("R10 pre hold o", int'(tmr_out), 1);
        hold_in = 1'b1; step();
        chk("R10 dark", int'(tmr_out), 0);
        start_in = 1'b1; step();
        start_in = 1'b0; clr_in = 1'b1; step();
        clr_in = 1'b0;
        chk("R10 held elapsed", int'(elapsed), 1);
        hold_in = 1'b0; step();
        chk("R10 restored out", int'(tmr_out), 1);
        chk("R10 restored e", int'(elapsed), 1);
        step();
        chk("R10 waits start", int'(elapsed), 1);
        do_start();
        chk("R10 start edge", int'(elapsed), 1);
        step();
        chk("R10 resumed", int'(elapsed), 2);
        step();
        chk("R10 wrap e", int'(elapsed), 0);
        chk("R10 wrap o", int'(tmr_out), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule